// File: doc/BRIEF.md
# Synchronous REQ/ACK Strobe Timing Generator

This block produces the handshake strobe for synchronous data transfers on a parallel SCSI bus. Software programs a transfer period in transfer clocks, an assertion delay and a deassertion adjustment, and then starts a transfer of a given number of bytes. For each byte the block marks the half-cycle in which data becomes valid, raises the REQ/ACK line after the chosen assertion delay, and drops it after the chosen deassertion point. When the last byte's period has elapsed it raises a done flag.

All timing uses half-cycle units. A clock enable, `hc_tick`, runs at twice the transfer clock rate, so every edge moves in half-cycle steps and the design stays in one clock domain. Nothing moves on a clock where `hc_tick` is low. The configuration is captured when a transfer starts, and the running transfer keeps it. The strobe controls are plain levels. The block has no data stream of its own, so it has no valid/ready back-pressure.

Top module: `scsi_reqack_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted start, `data_valid`, `req_ack` and `xfer_done` are all 0.
- R2: A start that is accepted with `byte_count` = N > 0 produces exactly N beats. Each beat lasts 2·Pe ticks, where Pe is the effective period. `data_valid` is high in the first tick of each beat (phase 0), and `xfer_done` rises N·2·Pe ticks after the start.
- R3: The effective period Pe equals `period_sel` when that value is 4 or more. Any value below 4 is treated as 4.
- R4: `asrt_sel` sets the assertion point A in half-cycles after data valid: 00=0, 01=1, 10=2, 11=3. `req_ack` rises at phase A of every beat, and when A=0 it rises together with `data_valid`.
- R5: With `fast_clk`=0, `deas_sel` moves the deassertion point from its nominal position at phase Pe: 00 = +0, 01 = +1, 10 = +2, 11 = +3 half-cycles.
- R6: With `fast_clk`=1, `deas_sel` moves the deassertion point as follows: 00 = +0, 01 = −1, 10 = +1, 11 = +2 half-cycles.
- R7: If the deassertion phase would fall at or before A, it is clamped to A+1. The pulse is therefore at least one half-cycle wide, it never starts before data valid, and it ends before the beat does.
- R8: After the last beat, `req_ack` and `data_valid` are 0 and `xfer_done` is 1. `xfer_done` stays 1 until the next accepted start clears it.
- R9: A start that arrives while a transfer runs is ignored, and so are the count and configuration that come with it. A start with `byte_count`=0 produces no beat and sets `xfer_done` on the next clock.
- R10: On a clock where `hc_tick` is 0, the phase and the outputs hold. Changes to `period_sel`, `asrt_sel`, `deas_sel` or `fast_clk` during a transfer do not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hc_tick | input | 1 | Half-cycle clock enable (twice the transfer clock rate) |
| xfer_start | input | 1 | Starts a transfer when the block is idle |
| byte_count | input | CNT_W | Number of beats in the transfer |
| period_sel | input | PER_W | Transfer period in transfer clocks |
| asrt_sel | input | 2 | Assertion delay code |
| deas_sel | input | 2 | Deassertion adjustment code |
| fast_clk | input | 1 | Selects the fast-clock deassertion table |
| data_valid | output | 1 | High in the half-cycle in which a beat's data becomes valid |
| req_ack | output | 1 | Handshake strobe |
| xfer_done | output | 1 | Transfer complete flag |

## Verification
Two events can fall on the same clock edge: the wrap from one beat to the next, and a foreign start pulse that carries a new count and configuration. The bench drives that start so that it is sampled on the exact edge where a five-clock beat wraps to phase 0. It then judges the transfer by its beat count, its total length and each beat's pulse position, all of which must match the original settings. A second scenario holds `hc_tick` low across part of a beat. It checks that both strobes stay frozen and that the transfer ends exactly as many clocks late as the tick was held.

// File: rtl/scsi_hs_pkg.sv
package scsi_hs_pkg;

  // Deassertion adjustment, biased by +1 so that it stays unsigned:
  // result = (half-cycle shift from nominal) + 1, range 0..4.
  function automatic logic [2:0] deas_bias(input logic fast, input logic [1:0] code);
    logic [2:0] b;
    if (!fast) begin
      b = {1'b0, code} + 3'd1;
    end else begin
      unique case (code)
        2'b00:   b = 3'd1;
        2'b01:   b = 3'd0;
        2'b10:   b = 3'd2;
        default: b = 3'd3;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/scsi_hs_cfg.sv
module scsi_hs_cfg #(
  parameter int unsigned PER_W = 5,
  parameter int unsigned DLY_W = 2,
  parameter int unsigned MIN_PER = 4,
  localparam int unsigned PH_W = PER_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PER_W-1:0] per_raw,
  input  logic [DLY_W-1:0] asr_code,
  input  logic [1:0]       deas_code,
  input  logic             fast,
  output logic [PH_W-1:0]  a_q,
  output logic [PH_W-1:0]  d_q,
  output logic [PH_W-1:0]  last_q
);
  import scsi_hs_pkg::*;

  logic [PER_W-1:0] per_eff;
  logic [PH_W-1:0]  a_new, d_raw, d_floor, d_new, last_new;

  always_comb begin
    per_eff  = (per_raw < PER_W'(MIN_PER)) ? PER_W'(MIN_PER) : per_raw;
    last_new = {per_eff, 1'b0} - PH_W'(1);
    a_new    = PH_W'(asr_code);
    d_raw    = PH_W'(per_eff) + PH_W'(deas_bias(fast, deas_code)) - PH_W'(1);
    d_floor  = a_new + PH_W'(1);
    d_new    = (d_raw < d_floor) ? d_floor : d_raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q    <= '0;
      d_q    <= PH_W'(1);
      last_q <= PH_W'(2 * MIN_PER - 1);
    end else if (load) begin
      a_q    <= a_new;
      d_q    <= d_new;
      last_q <= last_new;
    end
  end

  p_per_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> last_q >= PH_W'(2 * MIN_PER - 1));

  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (d_q > a_q) && (d_q <= last_q));

endmodule

// File: rtl/scsi_hs_seq.sv
module scsi_hs_seq #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PH_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic [PH_W-1:0]  last_ph,
  output logic             load,
  output logic             run,
  output logic [PH_W-1:0]  phase,
  output logic             done
);
  logic [CNT_W-1:0] beats_left;
  logic             at_end;

  assign load   = start && !run;
  assign at_end = (phase == last_ph);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run        <= 1'b0;
      phase      <= '0;
      beats_left <= '0;
      done       <= 1'b0;
    end else if (load) begin
      phase      <= '0;
      beats_left <= count;
      run        <= (count != '0);
      done       <= (count == '0);
    end else if (run && tick) begin
      if (at_end) begin
        phase <= '0;
        if (beats_left == CNT_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
        beats_left <= beats_left - CNT_W'(1);
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  p_start_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && start && count != '0) |=> run && phase == '0 && beats_left == $past(count));

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !tick) |=> $stable(beats_left) && $stable(phase));

  p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(phase) && $stable(beats_left) && run);

  p_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !start && at_end && beats_left == CNT_W'(1)) |=> done && !run);

endmodule

// File: rtl/scsi_hs_strobe.sv
module scsi_hs_strobe #(
  parameter int unsigned PH_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PH_W-1:0] phase,
  input  logic [PH_W-1:0] a_q,
  input  logic [PH_W-1:0] d_q,
  output logic            data_valid,
  output logic            req_ack
);
  always_comb begin
    data_valid = run && (phase == '0);
    req_ack    = run && (phase >= a_q) && (phase < d_q);
  end

  p_rise_with_dv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_ack) && a_q == '0) |-> data_valid);

  p_fall_not_at_dv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_ack) && run) |-> !data_valid);

endmodule

// File: rtl/scsi_reqack_gen.sv
module scsi_reqack_gen #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PER_W = 5,
  parameter int unsigned DLY_W = 2,
  localparam int unsigned PH_W = PER_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hc_tick,
  input  logic             xfer_start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [PER_W-1:0] period_sel,
  input  logic [DLY_W-1:0] asrt_sel,
  input  logic [1:0]       deas_sel,
  input  logic             fast_clk,
  output logic             data_valid,
  output logic             req_ack,
  output logic             xfer_done
);
  logic            load, run;
  logic [PH_W-1:0] phase, a_q, d_q, last_q;

  scsi_hs_cfg #(.PER_W(PER_W), .DLY_W(DLY_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .per_raw(period_sel), .asr_code(asrt_sel), .deas_code(deas_sel), .fast(fast_clk),
    .a_q(a_q), .d_q(d_q), .last_q(last_q)
  );

  scsi_hs_seq #(.CNT_W(CNT_W), .PH_W(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(hc_tick), .start(xfer_start), .count(byte_count),
    .last_ph(last_q), .load(load), .run(run), .phase(phase), .done(xfer_done)
  );

  scsi_hs_strobe #(.PH_W(PH_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .run(run), .phase(phase), .a_q(a_q), .d_q(d_q),
    .data_valid(data_valid), .req_ack(req_ack)
  );

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !req_ack && !data_valid);

endmodule

// File: tb/test_scsi_reqack_gen.sv
`timescale 1ns/1ps
module test_scsi_reqack_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hc_tick = 1'b1;
  logic        xfer_start = 1'b0;
  logic [15:0] byte_count = '0;
  logic [4:0]  period_sel = 5'd4;
  logic [1:0]  asrt_sel = '0;
  logic [1:0]  deas_sel = '0;
  logic        fast_clk = 1'b0;
  logic        data_valid, req_ack, xfer_done;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  scsi_reqack_gen i_scsi_reqack_gen (
    .clk(clk), .rst_n(rst_n), .hc_tick(hc_tick), .xfer_start(xfer_start),
    .byte_count(byte_count), .period_sel(period_sel), .asrt_sel(asrt_sel),
    .deas_sel(deas_sel), .fast_clk(fast_clk),
    .data_valid(data_valid), .req_ack(req_ack), .xfer_done(xfer_done)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_per(int per);
    return (per < 4) ? 4 : per;
  endfunction

  function automatic int exp_deas(int per, int a, int d, int fast);
    int pe, off, de;
    pe = eff_per(per);
    if (fast != 0) off = (d == 0) ? 0 : (d == 1) ? -1 : (d == 2) ? 1 : 2;
    else           off = d;
    de = pe + off;
    if (de < a + 1) de = a + 1;
    return de;
  endfunction

  // One transfer with optional tick freeze and optional disturbing start.
  task automatic xfer(int n, int per, int a, int d, int fast,
                      int fz_at, int fz_len, int dist_at, string wtag);
    int beats = 0, bstart = 0, rise = 0, total = -1;
    int off_err = 0, wid_err = 0, hold_err = 0;
    int de;
    bit pdv = 0, preq = 0, snap_req = 0, snap_dv = 0;
    de = exp_deas(per, a, d, fast);
    @(negedge clk);
    byte_count = 16'(n); period_sel = 5'(per); asrt_sel = 2'(a);
    deas_sel = 2'(d); fast_clk = 1'(fast); hc_tick = 1'b1; xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      if (k == 0) chk("R8", "done cleared by start", int'(xfer_done), 0);
      if (data_valid && !pdv) begin beats++; bstart = k; end
      if (req_ack && !preq) begin
        rise = k;
        if (fz_len == 0 && (k - bstart) != a) begin
          off_err++;
          $display("  beat rise offset %0d", k - bstart);
        end
      end
      if (!req_ack && preq && fz_len == 0 && (k - rise) != (de - a)) begin
        wid_err++;
        $display("  beat width %0d", k - rise);
      end
      if (fz_len > 0 && k > fz_at && k <= fz_at + fz_len)
        if (req_ack != snap_req || data_valid != snap_dv) hold_err++;
      pdv = data_valid; preq = req_ack;
      if (xfer_done) begin total = k; break; end
      if (fz_len > 0 && k == fz_at) begin
        hc_tick = 1'b0; snap_req = req_ack; snap_dv = data_valid;
      end
      if (fz_len > 0 && k == fz_at + fz_len) hc_tick = 1'b1;
      if (k == dist_at) begin
        xfer_start = 1'b1; byte_count = 16'(n + 5); period_sel = 5'd31;
        asrt_sel = 2'd0; deas_sel = 2'd3; fast_clk = ~fast_clk;
      end
      if (k == dist_at + 1) xfer_start = 1'b0;
      @(negedge clk);
    end
    xfer_start = 1'b0; hc_tick = 1'b1;
    chk("R2", "beat count", beats, n);
    chk("R2", "transfer length", total, n * 2 * eff_per(per) + fz_len);
    if (fz_len == 0) begin
      chk("R4", "assert offset errors", off_err, 0);
      chk(wtag, "pulse width errors", wid_err, 0);
    end else begin
      chk("R10", "outputs moved while tick low", hold_err, 0);
    end
    chk("R8", "req low at done", int'(req_ack), 0);
    chk("R8", "done held", int'(xfer_done), 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "req in reset", int'(req_ack), 0);
    chk("R1", "dv in reset", int'(data_valid), 0);
    chk("R1", "done in reset", int'(xfer_done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "req after reset", int'(req_ack), 0);
    chk("R1", "done after reset", int'(xfer_done), 0);
  endtask

  task automatic t_zero_count();
    int dv_seen = 0;
    @(negedge clk);
    byte_count = '0; xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    chk("R9", "done after zero count", int'(xfer_done), 1);
    for (int k = 0; k < 12; k++) begin
      if (data_valid || req_ack) dv_seen++;
      @(negedge clk);
    end
    chk("R9", "strobes after zero count", dv_seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    xfer(3, 4, 0, 0, 0, 0, 0, -1, "R5");     // R2 fastest, width 4
    xfer(2, 10, 2, 3, 0, 0, 0, -1, "R5");    // R5 +3
    xfer(2, 8, 1, 1, 1, 0, 0, -1, "R6");     // R6 -1
    xfer(1, 8, 3, 3, 1, 0, 0, -1, "R6");     // R6 +2
    xfer(2, 2, 1, 2, 0, 0, 0, -1, "R3");     // R3 floor to 4
    xfer(1, 4, 3, 1, 1, 0, 0, -1, "R7");     // R7 clamp to 1 half-cycle
    xfer(2, 6, 1, 0, 0, 3, 9, -1, "R10");    // R10 tick freeze
    xfer(3, 5, 0, 2, 1, 0, 0, 9, "R9");      // R9/R10 start at beat wrap
    t_zero_count();
    xfer(1, 31, 3, 3, 0, 0, 0, -1, "R5");    // longest period
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule